// File: doc/BRIEF.md
# Data-Processing ALU with Flag Update

This block is the execute stage for the register-to-register arithmetic and logic instructions of a 32-bit RISC core. Each accepted operation carries a 4-bit opcode, a set-flags bit, a destination register index, a first operand and a second operand. The second operand has already been through the barrel shifter, which also hands over its carry-out. The block forms the result and the destination write strobes. It also computes the next N, Z, C and V flags from the flags currently in force. All of these are registered, so they appear one clock after the request.

The caller owns the register file, the program counter and the flag register. When the destination index is 15, the block raises a program-counter write instead of a register write, so the fetch unit can redirect. When set-flags is asserted with destination 15, the block raises a status-load strobe and the top four result bits become the new flags. This happens for the compare opcodes too. Flag bits travel as a 4-bit vector ordered {N, Z, C, V}, with N in bit 3 and V in bit 0.

Top module: `dp_alu_top`

## Requirements
- R1: Outputs are registered. A request accepted with `inValid` high shows on the outputs after one rising clock edge, with `outValid` high. A cycle with `inValid` low gives `outValid`, `regWrEn`, `pcWrEn` and `statusLoad` all low. After reset every output is zero.
- R2: The logical opcodes produce the following results: 0 AND is A&B, 1 EOR is A^B, 12 ORR is A|B, 13 MOV is B, 14 BIC is A&~B, and 15 MVN is ~B.
- R3: The arithmetic opcodes produce the following results, modulo 2^32: 4 ADD is A+B, 5 ADC is A+B+C, 2 SUB is A-B, 3 RSB is B-A, 6 SBC is A-B+C-1, and 7 RSC is B-A+C-1.
- R4: The compare opcodes are 8 TST (A&B), 9 TEQ (A^B), 10 CMP (A-B) and 11 CMN (A+B). They drive `resultOut` with that value but never assert `regWrEn` or `pcWrEn`.
- R5: A logical or test opcode with set-flags high and destination other than 15 takes C from `shiftCarry` and keeps V unchanged.
- R6: ADD, ADC and CMN with set-flags high and destination other than 15 set C to the unsigned carry-out and V to the signed overflow.
- R7: SUB, RSB, SBC, RSC and CMP with set-flags high and destination other than 15 set C to 1 when no borrow occurs and to 0 on unsigned underflow. V is set to the signed overflow of the subtraction.
- R8: A non-compare opcode with destination 15 asserts `pcWrEn` and not `regWrEn`. With any other destination it asserts `regWrEn` and not `pcWrEn`.
- R9: When set-flags is high and the destination is 15, `statusLoad` is asserted and `flagsOut` equals `resultOut[31:28]`. This holds for every opcode, compares included.
- R10: When set-flags is low, `flagsOut` equals the `flagsIn` of that request and `statusLoad` is low.
- R11: On a normal flag update, N is bit 31 of the result and Z is 1 exactly when the 32-bit result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present this cycle |
| opcode | input | 4 | Operation code |
| setFlags | input | 1 | Update flags from this operation |
| destIdx | input | 4 | Destination register index |
| operandA | input | 32 | First operand |
| operandB | input | 32 | Shifted second operand |
| shiftCarry | input | 1 | Carry-out of the barrel shifter |
| flagsIn | input | 4 | Current flags {N,Z,C,V} |
| outValid | output | 1 | Registered result valid |
| resultOut | output | 32 | Operation value |
| regWrEn | output | 1 | Write result to a general register |
| pcWrEn | output | 1 | Write result to the program counter |
| statusLoad | output | 1 | Flags replaced from result top bits |
| flagsOut | output | 4 | Next flags {N,Z,C,V} |

## Verification
The assertions check the cycle relationships on every cycle: compares never write back, flags hold when set-flags is low, logical updates keep V, and a destination-15 flag update mirrors the result's top bits. They also check the one-cycle valid pipeline and the exclusive write strobes. Only the bench's scenarios can show the arithmetic values and the carry and overflow meaning. These include carry-in edge cases such as SBC with C clear at zero operands, signed overflow at 0x7fffffff and 0x80000000, and zero results that set Z. These are compared against an independent reference model.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [2:0] {
    LG_AND, LG_EOR, LG_ORR, LG_BIC, LG_MOV, LG_MVN
  } logicSel_e;

  typedef enum logic [1:0] {
    CIN_ZERO, CIN_ONE, CIN_FLAG
  } carrySel_e;

  typedef struct packed {
    logic      isLogic;
    logic      isCompare;
    logic      swapOps;
    logic      invertRhs;
    carrySel_e cinSel;
    logicSel_e logicSel;
  } aluCtrl_t;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

endpackage

// File: rtl/dp_alu_ctrl.sv
module dp_alu_ctrl
  import dp_alu_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [3:0]       opcode,
  input  logic             setFlags,
  input  logic [IDX_W-1:0] destIdx,
  output aluCtrl_t         ctrl,
  output logic             regWr,
  output logic             pcWr,
  output logic             statusLd
);

  logic destIsPc;
  assign destIsPc = (destIdx == IDX_W'(PC_IDX));

  always_comb begin
    ctrl = '{isLogic: 1'b0, isCompare: 1'b0, swapOps: 1'b0, invertRhs: 1'b0,
             cinSel: CIN_ZERO, logicSel: LG_AND};
    unique case (opcode)
      4'h0: begin ctrl.isLogic = 1'b1; ctrl.logicSel = LG_AND; end
      4'h1: begin ctrl.isLogic = 1'b1; ctrl.logicSel = LG_EOR; end
      4'h2: begin ctrl.invertRhs = 1'b1; ctrl.cinSel = CIN_ONE; end
      4'h3: begin ctrl.invertRhs = 1'b1; ctrl.cinSel = CIN_ONE; ctrl.swapOps = 1'b1; end
      4'h4: ctrl.cinSel = CIN_ZERO;
      4'h5: ctrl.cinSel = CIN_FLAG;
      4'h6: begin ctrl.invertRhs = 1'b1; ctrl.cinSel = CIN_FLAG; end
      4'h7: begin ctrl.invertRhs = 1'b1; ctrl.cinSel = CIN_FLAG; ctrl.swapOps = 1'b1; end
      4'h8: begin ctrl.isLogic = 1'b1; ctrl.isCompare = 1'b1; ctrl.logicSel = LG_AND; end
      4'h9: begin ctrl.isLogic = 1'b1; ctrl.isCompare = 1'b1; ctrl.logicSel = LG_EOR; end
      4'hA: begin ctrl.isCompare = 1'b1; ctrl.invertRhs = 1'b1; ctrl.cinSel = CIN_ONE; end
      4'hB: begin ctrl.isCompare = 1'b1; ctrl.cinSel = CIN_ZERO; end
      4'hC: begin ctrl.isLogic = 1'b1; ctrl.logicSel = LG_ORR; end
      4'hD: begin ctrl.isLogic = 1'b1; ctrl.logicSel = LG_MOV; end
      4'hE: begin ctrl.isLogic = 1'b1; ctrl.logicSel = LG_BIC; end
      default: begin ctrl.isLogic = 1'b1; ctrl.logicSel = LG_MVN; end
    endcase
  end

  assign regWr    = inValid && !ctrl.isCompare && !destIsPc;
  assign pcWr     = inValid && !ctrl.isCompare && destIsPc;
  assign statusLd = inValid && setFlags && destIsPc;

  // R8: the two write strobes never fire together
  always_comb begin
    a_r8_one_writer: assert (!(regWr && pcWr));
  end

  // R4: a compare opcode never produces a write strobe
  a_r4_ctrl_compare: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode[3:2] == 2'b10) |-> (!regWr && !pcWr));

endmodule

// File: rtl/dp_alu_datapath.sv
module dp_alu_datapath
  import dp_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluCtrl_t          ctrl,
  input  logic              setFlags,
  input  logic              statusLd,
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  input  logic              shiftCarry,
  input  logic [3:0]        flagsIn,
  output logic [DATA_W-1:0] value,
  output logic [3:0]        nextFlags
);

  logic [DATA_W-1:0] lhs, rhs, rhsEff, logicVal;
  logic [DATA_W:0]   sumWide;
  logic              carryIn, addCarry, addOvf;

  assign lhs    = ctrl.swapOps ? operandB : operandA;
  assign rhs    = ctrl.swapOps ? operandA : operandB;
  assign rhsEff = ctrl.invertRhs ? ~rhs : rhs;

  always_comb begin
    unique case (ctrl.cinSel)
      CIN_ONE:  carryIn = 1'b1;
      CIN_FLAG: carryIn = flagsIn[FLAG_C];
      default:  carryIn = 1'b0;
    endcase
  end

  assign sumWide  = {1'b0, lhs} + {1'b0, rhsEff} + {{DATA_W{1'b0}}, carryIn};
  assign addCarry = sumWide[DATA_W];
  assign addOvf   = (lhs[DATA_W-1] == rhsEff[DATA_W-1]) &&
                    (sumWide[DATA_W-1] != lhs[DATA_W-1]);

  always_comb begin
    unique case (ctrl.logicSel)
      LG_AND:  logicVal = operandA & operandB;
      LG_EOR:  logicVal = operandA ^ operandB;
      LG_ORR:  logicVal = operandA | operandB;
      LG_BIC:  logicVal = operandA & ~operandB;
      LG_MOV:  logicVal = operandB;
      default: logicVal = ~operandB;
    endcase
  end

  assign value = ctrl.isLogic ? logicVal : sumWide[DATA_W-1:0];

  always_comb begin
    nextFlags = flagsIn;
    if (setFlags) begin
      if (statusLd) begin
        nextFlags = value[DATA_W-1 -: 4];
      end else begin
        nextFlags[FLAG_N] = value[DATA_W-1];
        nextFlags[FLAG_Z] = (value == '0);
        nextFlags[FLAG_C] = ctrl.isLogic ? shiftCarry : addCarry;
        nextFlags[FLAG_V] = ctrl.isLogic ? flagsIn[FLAG_V] : addOvf;
      end
    end
  end

  // R11: a normal update reports the zero condition of the value
  a_r11_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    (setFlags && !statusLd) |-> (nextFlags[FLAG_Z] == (value == '0)));

endmodule

// File: rtl/dp_alu_top.sv
module dp_alu_top
  import dp_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [3:0]        opcode,
  input  logic              setFlags,
  input  logic [IDX_W-1:0]  destIdx,
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  input  logic              shiftCarry,
  input  logic [3:0]        flagsIn,
  output logic              outValid,
  output logic [DATA_W-1:0] resultOut,
  output logic              regWrEn,
  output logic              pcWrEn,
  output logic              statusLoad,
  output logic [3:0]        flagsOut
);

  aluCtrl_t          ctrl;
  logic              regWr, pcWr, statusLd;
  logic [DATA_W-1:0] value;
  logic [3:0]        nextFlags;

  dp_alu_ctrl #(.IDX_W(IDX_W), .PC_IDX(PC_IDX)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .setFlags(setFlags), .destIdx(destIdx), .ctrl(ctrl),
    .regWr(regWr), .pcWr(pcWr), .statusLd(statusLd)
  );

  dp_alu_datapath #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .setFlags(setFlags),
    .statusLd(statusLd), .operandA(operandA), .operandB(operandB),
    .shiftCarry(shiftCarry), .flagsIn(flagsIn),
    .value(value), .nextFlags(nextFlags)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      resultOut  <= '0;
      regWrEn    <= 1'b0;
      pcWrEn     <= 1'b0;
      statusLoad <= 1'b0;
      flagsOut   <= '0;
    end else begin
      outValid   <= inValid;
      regWrEn    <= regWr;
      pcWrEn     <= pcWr;
      statusLoad <= statusLd;
      if (inValid) begin
        resultOut <= value;
        flagsOut  <= nextFlags;
      end
    end
  end

  // R1: valid follows the request by one cycle
  a_r1_valid_pipe: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (outValid == $past(inValid)));

  // R4: compares never write back
  a_r4_no_writeback: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode[3:2] == 2'b10) |=> (!regWrEn && !pcWrEn));

  // R10: flags hold when set-flags is low
  a_r10_hold_flags: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !setFlags) |=> (flagsOut == $past(flagsIn) && !statusLoad));

  // R9: status load copies the top result bits
  a_r9_status_copy: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && setFlags && destIdx == IDX_W'(PC_IDX)) |=>
      (statusLoad && flagsOut == resultOut[DATA_W-1 -: 4]));

  // R5: logical updates keep V
  a_r5_logic_keeps_v: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && setFlags && destIdx != IDX_W'(PC_IDX) &&
     (opcode inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF})) |=>
      (flagsOut[FLAG_V] == $past(flagsIn[FLAG_V]) &&
       flagsOut[FLAG_C] == $past(shiftCarry)));

  // R8: write strobes are exclusive
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && pcWrEn));

endmodule

// File: tb/tb_dp_alu_top.sv
module tb_dp_alu_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  opcode = '0;
  logic        setFlags = 1'b0;
  logic [3:0]  destIdx = '0;
  logic [31:0] operandA = '0;
  logic [31:0] operandB = '0;
  logic        shiftCarry = 1'b0;
  logic [3:0]  flagsIn = '0;
  logic        outValid, regWrEn, pcWrEn, statusLoad;
  logic [31:0] resultOut;
  logic [3:0]  flagsOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dp_alu_top dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .setFlags(setFlags), .destIdx(destIdx), .operandA(operandA),
    .operandB(operandB), .shiftCarry(shiftCarry), .flagsIn(flagsIn),
    .outValid(outValid), .resultOut(resultOut), .regWrEn(regWrEn),
    .pcWrEn(pcWrEn), .statusLoad(statusLoad), .flagsOut(flagsOut)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit isCmp(input logic [3:0] op);
    return op >= 4'h8 && op <= 4'hB;
  endfunction

  function automatic bit isLog(input logic [3:0] op);
    return op inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF};
  endfunction

  // reference: value, carry, overflow
  task automatic refModel(input logic [3:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic cf,
                          output logic [31:0] val, output logic c,
                          output logic v);
    longint unsigned ua, ub, us;
    longint sa, sb, ss;
    logic [31:0] l, r;
    int cin;
    bit sub;
    c = 1'b0; v = 1'b0; val = '0;
    sub = 1'b0; cin = 0; l = a; r = b;
    case (op)
      4'h0, 4'h8: val = a & b;
      4'h1, 4'h9: val = a ^ b;
      4'hC: val = a | b;
      4'hD: val = b;
      4'hE: val = a & ~b;
      4'hF: val = ~b;
      4'h4, 4'hB: cin = 0;
      4'h5: cin = int'(cf);
      4'h2, 4'hA: begin sub = 1'b1; cin = 1; end
      4'h3: begin sub = 1'b1; cin = 1; l = b; r = a; end
      4'h6: begin sub = 1'b1; cin = int'(cf); end
      default: begin sub = 1'b1; cin = int'(cf); l = b; r = a; end
    endcase
    if (!isLog(op)) begin
      ua = longint'(l); ub = longint'(r);
      sa = longint'($signed(l)); sb = longint'($signed(r));
      if (sub) begin
        c  = (ua >= ub + longint'(1 - cin));
        ss = sa - sb - longint'(1 - cin);
        val = l - r - 32'(1 - cin);
      end else begin
        us = ua + ub + longint'(cin);
        c  = us[32];
        ss = sa + sb + longint'(cin);
        val = l + r + 32'(cin);
      end
      v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
    end
  endtask

  task automatic runOne(input logic [3:0] op, input logic s, input logic [3:0] d,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic sc, input logic [3:0] fl);
    logic [31:0] val;
    logic c, v;
    logic [3:0] ef;
    string rq;
    refModel(op, a, b, fl[1], val, c, v);
    ef = fl;
    if (s) begin
      if (d == 4'd15) ef = val[31:28];
      else begin
        ef[3] = val[31];
        ef[2] = (val == 32'd0);
        ef[1] = isLog(op) ? sc : c;
        ef[0] = isLog(op) ? fl[0] : v;
      end
    end
    @(negedge clk);
    inValid = 1'b1; opcode = op; setFlags = s; destIdx = d;
    operandA = a; operandB = b; shiftCarry = sc; flagsIn = fl;
    @(posedge clk);
    #1;
    inValid = 1'b0;
    if (isCmp(op)) rq = "R4";
    else if (isLog(op)) rq = "R2";
    else rq = "R3";
    check("R1", "outValid", 32'(outValid), 32'd1);
    check(rq, "result", resultOut, val);
    check(isCmp(op) ? "R4" : "R8", "regWrEn", 32'(regWrEn),
          32'(!isCmp(op) && d != 4'd15));
    check(isCmp(op) ? "R4" : "R8", "pcWrEn", 32'(pcWrEn),
          32'(!isCmp(op) && d == 4'd15));
    check("R9", "statusLoad", 32'(statusLoad), 32'(s && d == 4'd15));
    if (!s) rq = "R10";
    else if (d == 4'd15) rq = "R9";
    else if (isLog(op)) rq = "R5";
    else if (op inside {4'h4, 4'h5, 4'hB}) rq = "R6";
    else rq = "R7";
    check(rq, "flags", 32'(flagsOut), 32'(ef));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "reset outValid", 32'(outValid), 32'd0);
    check("R1", "reset result", resultOut, 32'd0);
    check("R1", "reset flags", 32'(flagsOut), 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R11 zero result sets Z, N from bit 31
    runOne(4'h2, 1'b1, 4'd1, 32'h1234, 32'h1234, 1'b0, 4'b0000);
    check("R11", "Z on zero", 32'(flagsOut[2]), 32'd1);
    runOne(4'hD, 1'b1, 4'd2, 32'h0, 32'h8000_0000, 1'b1, 4'b0001);
    check("R11", "N on bit31", 32'(flagsOut[3]), 32'd1);
    // R6 carry and overflow edges
    runOne(4'h4, 1'b1, 4'd3, 32'hFFFF_FFFF, 32'h1, 1'b0, 4'b0000);
    runOne(4'h4, 1'b1, 4'd3, 32'h7FFF_FFFF, 32'h1, 1'b0, 4'b0000);
    runOne(4'h5, 1'b1, 4'd3, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'b0010);
    runOne(4'hB, 1'b1, 4'd3, 32'h8000_0000, 32'h8000_0000, 1'b0, 4'b0000);
    // R7 borrow edges
    runOne(4'hA, 1'b1, 4'd0, 32'h0, 32'h1, 1'b0, 4'b0000);
    runOne(4'h6, 1'b1, 4'd0, 32'h0, 32'h0, 1'b0, 4'b0000);
    runOne(4'h7, 1'b1, 4'd0, 32'h5, 32'h5, 1'b0, 4'b0010);
    runOne(4'h2, 1'b1, 4'd0, 32'h8000_0000, 32'h1, 1'b0, 4'b0000);
    runOne(4'h3, 1'b1, 4'd0, 32'h1, 32'h7FFF_FFFF, 1'b0, 4'b0000);
    // R5 logical keeps V, takes shift carry
    runOne(4'h0, 1'b1, 4'd4, 32'hF0F0, 32'h0FF0, 1'b1, 4'b0001);
    runOne(4'h9, 1'b1, 4'd4, 32'hAAAA, 32'hAAAA, 1'b0, 4'b1011);
    // R9 status load, including compare
    runOne(4'hA, 1'b1, 4'd15, 32'hA000_0000, 32'h0, 1'b0, 4'b0000);
    runOne(4'hD, 1'b1, 4'd15, 32'h0, 32'h5000_0000, 1'b0, 4'b1111);
    // R8 pc write without flags; R10 hold
    runOne(4'h4, 1'b0, 4'd15, 32'h100, 32'h8, 1'b0, 4'b1010);
    // R1 idle cycle: no strobes
    @(negedge clk);
    @(posedge clk);
    #1;
    check("R1", "idle outValid", 32'(outValid), 32'd0);
    check("R1", "idle regWrEn", 32'(regWrEn), 32'd0);
    check("R1", "idle pcWrEn", 32'(pcWrEn), 32'd0);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (i % 7 == 0) rb = ra;
      if (i % 11 == 0) ra = 32'h8000_0000;
      runOne(4'($urandom()), 1'($urandom()),
             ($urandom() % 4 == 0) ? 4'd15 : 4'($urandom()),
             ra, rb, 1'($urandom()), 4'($urandom()));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule